// File: doc/BRIEF.md
# Input Capture Channel with Edge Select

This block is one timer channel run in capture mode. A free-running counter value is presented on its input. The channel picks one of three candidate input lines and brings the chosen line into the clock domain through a synchronizer. It then qualifies rising edges, falling edges or both, according to a two-bit polarity setting. An edge divider lets only every Nth qualifying edge through. Each edge that passes stores the current counter value into the capture register.

Each capture raises a capture flag. The flag stays set until software clears it. An interrupt request follows the flag when the interrupt enable is high. If a new capture arrives while the flag is still set, the register is overwritten and a separate overcapture flag records that a value was lost. The capture register is the same storage a neighbouring compare path would read as its compare value.

Top module: `cap_chan`

## Requirements
- R1: After reset, the capture value is 0 and the capture flag, overcapture flag and interrupt request are all 0.
- R2: `src_sel_i` picks the line to watch: 0 and 3 select `src_own_i`, 1 selects `src_alt_i`, 2 selects `src_trig_i`. Activity on lines that are not selected causes no capture.
- R3: With polarity (`pol_pri_i`=0, `pol_sec_i`=0), only rising edges of the selected line qualify. The unused combination (`pol_pri_i`=0, `pol_sec_i`=1) behaves the same way.
- R4: With polarity (`pol_pri_i`=1, `pol_sec_i`=0), only falling edges qualify.
- R5: With polarity (`pol_pri_i`=1, `pol_sec_i`=1), both rising and falling edges qualify.
- R6: `psc_i` values 0, 1, 2 and 3 give a capture on every 1st, 2nd, 4th and 8th qualifying edge. Counting starts from zero after reset and restarts after each capture.
- R7: A change on the selected line is sampled at the first rising clock edge after it. The capture register takes the value `cnt_i` holds at the third rising clock edge. The flag shows the capture after that same edge.
- R8: Every capture sets `cap_flag_o`. The flag holds until a cycle with `flag_clr_i` high. When a capture and a clear fall in the same cycle, the capture wins and the flag stays set.
- R9: `irq_o` is high exactly when `cap_flag_o` is high and `irq_en_i` is high, in the same cycle.
- R10: A capture while `cap_flag_o` is already set still overwrites the capture value and sets `ovr_flag_o`. This holds even when `flag_clr_i` is high in that cycle. `ovr_flag_o` holds until a cycle with `ovr_clr_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Counter value to be captured |
| src_own_i | input | 1 | Channel's own input line |
| src_alt_i | input | 1 | Alternate input line from the neighbouring channel |
| src_trig_i | input | 1 | Trigger input line |
| src_sel_i | input | 2 | Input line select |
| pol_pri_i | input | 1 | Primary polarity bit |
| pol_sec_i | input | 1 | Secondary polarity bit |
| psc_i | input | 2 | Edge divider setting (divide by 1, 2, 4, 8) |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clears the capture flag |
| ovr_clr_i | input | 1 | Clears the overcapture flag |
| cap_val_o | output | CNT_W | Captured counter value |
| cap_flag_o | output | 1 | Capture flag |
| ovr_flag_o | output | 1 | Overcapture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a capture that lands in the very cycle software clears the flag. The bench gets there by counting the synchronizer and edge stages from the moment it drives the input line, and raising the clear exactly on the capture edge. The divide-by-8 setting with both edges enabled also needs a long, exact edge train. The bench walks it in table rows that reset the divider first, while the unselected lines toggle between the selected edges, so that a wrong select would add stray captures.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        SRC_OWN   = 2'd0,
        SRC_ALT   = 2'd1,
        SRC_TRIG  = 2'd2,
        SRC_OWN_B = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic pri;
        logic sec;
    } pol_t;
endpackage

// File: rtl/cap_insync.sv
module cap_insync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] srcs_i,
    input  logic [1:0] sel_i,
    output logic       rise_o,
    output logic       fall_o
);
    import cap_pkg::*;

    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;
    logic              pick;

    always_comb begin
        case (src_sel_e'(sel_i))
            SRC_ALT:  pick = srcs_i[1];
            SRC_TRIG: pick = srcs_i[2];
            default:  pick = srcs_i[0];
        endcase
        chain_d[0] = pick;
        prev_d     = chain_q[STAGES-1];
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign chain_d[g] = chain_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign rise_o =  chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/cap_edge_sel.sv
module cap_edge_sel (
    input  logic rise_i,
    input  logic fall_i,
    input  logic pol_pri_i,
    input  logic pol_sec_i,
    output logic ev_o
);
    import cap_pkg::*;

    pol_t pol;

    always_comb begin
        pol = '{pri: pol_pri_i, sec: pol_sec_i};
        if (pol.pri && pol.sec)
            ev_o = rise_i | fall_i;
        else if (pol.pri)
            ev_o = fall_i;
        else
            ev_o = rise_i;
    end
endmodule

// File: rtl/cap_evdiv.sv
module cap_evdiv #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             fire_o
);
    localparam int CNT_W = (1 << PSC_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] target;

    always_comb begin
        target = CNT_W'((1 << psc_i) - 1);
        fire_o = ev_i && (cnt_q >= target);
        if (fire_o)
            cnt_d = '0;
        else if (ev_i)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cap_chan.sv
module cap_chan #(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             src_own_i,
    input  logic             src_alt_i,
    input  logic             src_trig_i,
    input  logic [1:0]       src_sel_i,
    input  logic             pol_pri_i,
    input  logic             pol_sec_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic             irq_en_i,
    input  logic             flag_clr_i,
    input  logic             ovr_clr_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             cap_flag_o,
    output logic             ovr_flag_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             flag;
        logic             ovr;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     rise, fall, ev, fire;

    cap_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .srcs_i ({src_trig_i, src_alt_i, src_own_i}),
        .sel_i  (src_sel_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    cap_edge_sel u_edge (
        .rise_i    (rise),
        .fall_i    (fall),
        .pol_pri_i (pol_pri_i),
        .pol_sec_i (pol_sec_i),
        .ev_o      (ev)
    );

    cap_evdiv #(.PSC_W(PSC_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev),
        .psc_i  (psc_i),
        .fire_o (fire)
    );

    always_comb begin
        st_d = st_q;
        if (flag_clr_i) st_d.flag = 1'b0;
        if (ovr_clr_i)  st_d.ovr  = 1'b0;
        if (fire) begin
            st_d.val  = cnt_i;
            st_d.flag = 1'b1;
            if (st_q.flag) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_val_o  = st_q.val;
    assign cap_flag_o = st_q.flag;
    assign ovr_flag_o = st_q.ovr;
    assign irq_o      = st_q.flag & irq_en_i;
endmodule

// File: rtl/cap_chan_chk.sv
module cap_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flag_clr_i,
    input logic             ovr_clr_i,
    input logic [CNT_W-1:0] cap_val_o,
    input logic             cap_flag_o,
    input logic             ovr_flag_o
);
    // R8
    val_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val_o) |-> cap_flag_o);

    // R8
    flag_drop_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_flag_o) |-> $past(flag_clr_i));

    // R10
    ovr_needs_prior_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag_o) |-> $past(cap_flag_o));

    // R10
    ovr_drop_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_flag_o) |-> $past(ovr_clr_i));
endmodule

bind cap_chan cap_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_clr_i (flag_clr_i),
    .ovr_clr_i  (ovr_clr_i),
    .cap_val_o  (cap_val_o),
    .cap_flag_o (cap_flag_o),
    .ovr_flag_o (ovr_flag_o)
);

// File: tb/tb_cap_chan.sv
module tb_cap_chan;
    typedef struct packed {
        logic [1:0] sel;
        logic       pri;
        logic       sec;
        logic [1:0] psc;
        logic [4:0] pulses;
        logic [4:0] caps;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 1'b0, 2'd0, 5'd3, 5'd3},  // R3 rising
        '{2'd0, 1'b1, 1'b0, 2'd0, 5'd3, 5'd3},  // R4 falling
        '{2'd0, 1'b1, 1'b1, 2'd0, 5'd3, 5'd6},  // R5 both
        '{2'd0, 1'b0, 1'b0, 2'd1, 5'd4, 5'd2},  // R6 div2
        '{2'd0, 1'b1, 1'b1, 2'd2, 5'd4, 5'd2},  // R6 div4
        '{2'd0, 1'b1, 1'b1, 2'd3, 5'd8, 5'd2},  // R6 div8
        '{2'd1, 1'b0, 1'b0, 2'd0, 5'd2, 5'd2},  // R2 alt
        '{2'd2, 1'b1, 1'b0, 2'd0, 5'd2, 5'd2},  // R2 trig
        '{2'd3, 1'b1, 1'b1, 2'd0, 5'd2, 5'd4},  // R2 sel3 own
        '{2'd0, 1'b0, 1'b1, 2'd0, 5'd2, 5'd2}   // R3 unused combo
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = '0;
    logic [2:0]  srcs = '0;
    logic [1:0]  sel = '0;
    logic        pri = 1'b0, sec = 1'b0;
    logic [1:0]  psc = '0;
    logic        irq_en = 1'b0, fclr = 1'b0, oclr = 1'b0;
    logic [15:0] cap_val;
    logic        cap_flag, ovr_flag, irq;

    int tests = 0;
    int fails = 0;
    int caps;

    always #4 clk = ~clk;

    cap_chan dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt),
        .src_own_i  (srcs[0]),
        .src_alt_i  (srcs[1]),
        .src_trig_i (srcs[2]),
        .src_sel_i  (sel),
        .pol_pri_i  (pri),
        .pol_sec_i  (sec),
        .psc_i      (psc),
        .irq_en_i   (irq_en),
        .flag_clr_i (fclr),
        .ovr_clr_i  (oclr),
        .cap_val_o  (cap_val),
        .cap_flag_o (cap_flag),
        .ovr_flag_o (ovr_flag),
        .irq_o      (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        srcs  = '0;
        fclr  = 1'b0;
        oclr  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_fclr();
        fclr = 1'b1;
        @(negedge clk);
        fclr = 1'b0;
    endtask

    // drive one level on the selected line, toggle the others, then tally
    task automatic half_step(input int idx, input logic lvl);
        srcs[idx] = lvl;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            for (int j = 0; j < 3; j++)
                if (j != idx) srcs[j] = ~srcs[j];
        end
        repeat (4) @(negedge clk);
        if (cap_flag) begin
            caps++;
            pulse_fclr();
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        // R1 reset state
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 val",  32'(cap_val), 32'h0);
        check("R1 flag", 32'(cap_flag), 32'h0);
        check("R1 ovr",  32'(ovr_flag), 32'h0);
        check("R1 irq",  32'(irq), 32'h0);

        // table-driven walk
        for (int v = 0; v < NV; v++) begin
            int idx;
            sel = VEC[v].sel;
            pri = VEC[v].pri;
            sec = VEC[v].sec;
            psc = VEC[v].psc;
            idx = (VEC[v].sel == 2'd3) ? 0 : int'(VEC[v].sel);
            do_reset();
            caps = 0;
            for (int p = 0; p < int'(VEC[v].pulses); p++) begin
                cnt = 16'(v * 64 + p);
                half_step(idx, 1'b1);
                half_step(idx, 1'b0);
            end
            check($sformatf("R2-R6 row %0d captures", v), 32'(caps), 32'(VEC[v].caps));
        end

        // R7 exact latency and sampled counter value
        sel = 2'd0; pri = 1'b0; sec = 1'b0; psc = 2'd0; irq_en = 1'b0;
        do_reset();
        cnt = 16'h1111;
        srcs[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 no flag before third edge", 32'(cap_flag), 32'h0);
        cnt = 16'hA5A5;
        @(negedge clk);
        check("R7 flag after third edge", 32'(cap_flag), 32'h1);
        check("R7 value from third edge", 32'(cap_val), 32'hA5A5);

        // R9 interrupt gating
        check("R9 irq masked", 32'(irq), 32'h0);
        irq_en = 1'b1;
        #1;
        check("R9 irq enabled", 32'(irq), 32'h1);

        // R10 overcapture
        srcs[0] = 1'b0;
        repeat (4) @(negedge clk);
        cnt = 16'hBEEF;
        srcs[0] = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 overwrite", 32'(cap_val), 32'hBEEF);
        check("R10 ovr set", 32'(ovr_flag), 32'h1);

        // R8 clear flag, ovr stays
        pulse_fclr();
        check("R8 flag cleared", 32'(cap_flag), 32'h0);
        check("R9 irq follows flag", 32'(irq), 32'h0);
        check("R10 ovr holds", 32'(ovr_flag), 32'h1);
        check("R8 value kept on clear", 32'(cap_val), 32'hBEEF);
        oclr = 1'b1;
        @(negedge clk);
        oclr = 1'b0;
        check("R10 ovr cleared", 32'(ovr_flag), 32'h0);

        // R8 capture with no prior flag: flag set, no overcapture
        srcs[0] = 1'b0;
        repeat (4) @(negedge clk);
        cnt = 16'h0101;
        srcs[0] = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 flag set", 32'(cap_flag), 32'h1);
        check("R10 no ovr on first capture", 32'(ovr_flag), 32'h0);

        // R8/R10 capture in the same cycle as the clear
        srcs[0] = 1'b0;
        repeat (4) @(negedge clk);
        cnt = 16'h7E7E;
        srcs[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        fclr = 1'b1;
        @(negedge clk);
        fclr = 1'b0;
        check("R8 capture beats clear", 32'(cap_flag), 32'h1);
        check("R10 ovr with clear", 32'(ovr_flag), 32'h1);
        check("R8 value with clear", 32'(cap_val), 32'h7E7E);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule